// File: doc/BRIEF.md
# Recirculating Multi-Pass Pipeline Scheduler

This block keeps a fixed-latency compute pipeline busy when each operation needs several trips through it, as an iterative divider does when it produces a few quotient digits per trip. Callers own a set of request slots. Each slot takes one operation at a time through its own valid/ready pair. A fixed-priority picker sends one waiting entry per cycle into the pipeline.

When an item leaves the pipeline and still needs more passes, it is parked in a dedicated partial-result slot. That slot is addressed by the item's pass number and its owning slot. Because each owner has at most one item anywhere in the machine, the parking place is always free, so the pipeline never stalls. Finished items appear on a result port as a one-cycle pulse carrying the owner's slot number. That port cannot be back-pressured.

A per-slot cancel mask removes an operation wherever it is at that moment: waiting, parked or inside the pipeline. Each pass here applies a stand-in transform: the payload grows by the pass number plus one.

Top module: `recirc_sched`

## Requirements
- R1: After reset every `req_ready` bit is 1 and `res_valid` is 0.
- R2: `req_ready[s]` is 0 from the cycle after slot s accepts a request until the cycle after its result pulse or its cancel. It is also 0 in any cycle where `cancel[s]` is 1. An accept happens when `req_valid[s]` and `req_ready[s]` are both 1 at a clock edge. A low `req_ready` back-pressures the caller, who must hold its request.
- R3: At most one entry enters the pipeline per cycle. Parked entries (pass 1 to P-1) win over fresh entries (pass 0). Within parked entries, the lowest index pass*N+slot wins. Within fresh entries, the lowest slot wins. A cancelled slot is never picked.
- R4: Each pass p (numbered 0 to P-1) adds p+1 to the payload, modulo 2^DW. A final result therefore equals the request data plus P*(P+1)/2, which is +10 by default.
- R5: Every operation makes exactly P passes. Each pass takes LAT cycles in the pipeline plus one cycle parked. The result pulse carries the owning slot number on `res_slot`.
- R6: A parked item is always written to an empty partial slot. Every accepted operation ends either as one result pulse or as a cancel; none is lost.
- R7: When `cancel[s]` is 1 in a cycle, slot s's waiting entry, parked entries and pipeline stages are removed at that edge. No result for s appears in that cycle or later. Other slots are unaffected.
- R8: `res_valid` is a single-cycle pulse per operation. There are never two consecutive pulses for the same slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | N | Request valid, one bit per slot |
| req_ready | output | N | Slot can accept a request |
| req_data | input | N*DW | Request payloads; slot s at bits [s*DW +: DW] |
| cancel | input | N | Cancel mask, one bit per slot |
| res_valid | output | 1 | Final result pulse |
| res_slot | output | clog2(N) | Slot that owns the result |
| res_data | output | DW | Final payload |

## Verification
Several input patterns are used, each separating a different class of fault.
- A lone request shows the bare per-pass latency and the wrap of the payload sum past 2^DW.
- All slots requesting in the same cycle show whether parked entries really overtake fresh ones and whether the index order holds.
- A long random load with overlapping operations tests slot reuse and the ready handshake.
- A random load with sparse cancels hits items that are waiting, parked or mid-pipeline. It shows whether a kill reaches every copy without disturbing neighbours.

// File: rtl/recirc_pkg.sv
package recirc_pkg;
  function automatic int unsigned bits_for(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/recirc_pick.sv
module recirc_pick
  import recirc_pkg::*;
#(
  parameter int unsigned NREQ  = 40,
  parameter int unsigned SPLIT = 10,
  localparam int unsigned IW   = bits_for(NREQ)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NREQ-1:0] req,
  output logic            any,
  output logic [IW-1:0]   idx
);
  // upper group (parked) first, lowest index wins in each group
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = int'(NREQ) - 1; i >= int'(SPLIT); i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
    if (!any) begin
      for (int i = int'(SPLIT) - 1; i >= 0; i--) begin
        if (req[i]) begin
          any = 1'b1;
          idx = IW'(i);
        end
      end
    end
  end

  assert_pick_valid_R3: assert property (@(posedge clk) disable iff (rst)
    any |-> req[idx]);
  assert_pick_prio_R3: assert property (@(posedge clk) disable iff (rst)
    (any && (int'(idx) < int'(SPLIT))) |-> !(|req[NREQ-1:SPLIT]));
endmodule

// File: rtl/recirc_bank.sv
module recirc_bank
  import recirc_pkg::*;
#(
  parameter int unsigned N   = 10,
  parameter int unsigned P   = 4,
  parameter int unsigned DW  = 16,
  localparam int unsigned TOT = N * P,
  localparam int unsigned IW  = bits_for(TOT)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    acc,
  input  logic [N*DW-1:0] acc_data,
  input  logic            wb_en,
  input  logic [IW-1:0]   wb_idx,
  input  logic [DW-1:0]   wb_data,
  input  logic            iss_en,
  input  logic [IW-1:0]   iss_idx,
  input  logic [N-1:0]    cancel,
  output logic [TOT-1:0]  ent_valid,
  output logic [DW-1:0]   iss_data
);
  logic [DW-1:0] mem   [TOT];
  logic [DW-1:0] set_d [TOT];
  logic [TOT-1:0] set_v;
  logic [TOT-1:0] kill;

  for (genvar p = 0; p < int'(P); p++) begin : g_pass
    for (genvar s = 0; s < int'(N); s++) begin : g_slot
      localparam int unsigned K = p * N + s;
      assign kill[K] = cancel[s];
      if (p == 0) begin : g_fresh
        assign set_v[K] = acc[s];
        assign set_d[K] = acc_data[s*DW +: DW];
      end else begin : g_park
        assign set_v[K] = wb_en && (int'(wb_idx) == int'(K));
        assign set_d[K] = wb_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < int'(TOT); k++) begin
      if (rst || kill[k]) ent_valid[k] <= 1'b0;
      else if (set_v[k]) ent_valid[k] <= 1'b1;
      else if (iss_en && (int'(iss_idx) == k)) ent_valid[k] <= 1'b0;
      if (set_v[k]) mem[k] <= set_d[k];
    end
  end

  assign iss_data = (int'(iss_idx) < int'(TOT)) ? mem[iss_idx] : '0;

  assert_wb_free_R6: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> !ent_valid[wb_idx]);
endmodule

// File: rtl/recirc_pipe.sv
module recirc_pipe
  import recirc_pkg::*;
#(
  parameter int unsigned N   = 10,
  parameter int unsigned P   = 4,
  parameter int unsigned DW  = 16,
  parameter int unsigned LAT = 3,
  localparam int unsigned SW = bits_for(N),
  localparam int unsigned PW = bits_for(P),
  localparam int unsigned NX = 1 << SW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_v,
  input  logic [SW-1:0] in_slot,
  input  logic [PW-1:0] in_pass,
  input  logic [DW-1:0] in_data,
  input  logic [N-1:0]  cancel,
  output logic          out_v,
  output logic [SW-1:0] out_slot,
  output logic [PW-1:0] out_pass,
  output logic [DW-1:0] out_data
);
  typedef struct packed {
    logic          v;
    logic [SW-1:0] slot;
    logic [PW-1:0] pass;
    logic [DW-1:0] data;
  } stage_t;

  stage_t st [LAT];
  logic [NX-1:0] cx;
  assign cx = NX'(cancel);

  always_ff @(posedge clk) begin
    st[0].slot <= in_slot;
    st[0].pass <= in_pass;
    st[0].data <= in_data + DW'(in_pass) + DW'(1);
    st[0].v    <= rst ? 1'b0 : in_v;
    for (int k = 1; k < int'(LAT); k++) begin
      st[k].slot <= st[k-1].slot;
      st[k].pass <= st[k-1].pass;
      st[k].data <= st[k-1].data;
      st[k].v    <= rst ? 1'b0 : (st[k-1].v && !cx[st[k-1].slot]);
    end
  end

  assign out_v    = st[LAT-1].v;
  assign out_slot = st[LAT-1].slot;
  assign out_pass = st[LAT-1].pass;
  assign out_data = st[LAT-1].data;

  for (genvar k = 1; k < int'(LAT); k++) begin : g_chk
    assert_stage_kill_R7: assert property (@(posedge clk) disable iff (rst)
      (st[k-1].v && cx[st[k-1].slot]) |=> !st[k].v);
  end
endmodule

// File: rtl/recirc_sched.sv
module recirc_sched
  import recirc_pkg::*;
#(
  parameter int unsigned N   = 10,
  parameter int unsigned P   = 4,
  parameter int unsigned DW  = 16,
  parameter int unsigned LAT = 3,
  localparam int unsigned SW  = bits_for(N),
  localparam int unsigned PW  = bits_for(P),
  localparam int unsigned TOT = N * P,
  localparam int unsigned IW  = bits_for(TOT),
  localparam int unsigned NX  = 1 << SW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    req_valid,
  output logic [N-1:0]    req_ready,
  input  logic [N*DW-1:0] req_data,
  input  logic [N-1:0]    cancel,
  output logic            res_valid,
  output logic [SW-1:0]   res_slot,
  output logic [DW-1:0]   res_data
);
  logic [N-1:0]   busy_q;
  logic [N-1:0]   acc;
  logic [TOT-1:0] ent_valid, cand;
  logic           iss_en;
  logic [IW-1:0]  iss_idx, wb_idx;
  logic [DW-1:0]  iss_data;
  logic [SW-1:0]  iss_slot, o_slot;
  logic [PW-1:0]  iss_pass, o_pass;
  logic           o_v, live, fin;
  logic [DW-1:0]  o_data;
  logic [NX-1:0]  cx;

  assign cx        = NX'(cancel);
  assign req_ready = ~busy_q & ~cancel;
  assign acc       = req_valid & req_ready;

  for (genvar k = 0; k < int'(TOT); k++) begin : g_cand
    assign cand[k] = ent_valid[k] && !cancel[k % N];
  end

  recirc_pick #(.NREQ(TOT), .SPLIT(N)) u_pick (
    .clk(clk), .rst(rst), .req(cand), .any(iss_en), .idx(iss_idx)
  );

  assign iss_slot = SW'(int'(iss_idx) % int'(N));
  assign iss_pass = PW'(int'(iss_idx) / int'(N));

  recirc_pipe #(.N(N), .P(P), .DW(DW), .LAT(LAT)) u_pipe (
    .clk(clk), .rst(rst), .in_v(iss_en), .in_slot(iss_slot),
    .in_pass(iss_pass), .in_data(iss_data), .cancel(cancel),
    .out_v(o_v), .out_slot(o_slot), .out_pass(o_pass), .out_data(o_data)
  );

  assign live   = o_v && !cx[o_slot];
  assign fin    = live && (int'(o_pass) == int'(P) - 1);
  assign wb_idx = IW'((int'(o_pass) + 1) * int'(N) + int'(o_slot));

  recirc_bank #(.N(N), .P(P), .DW(DW)) u_bank (
    .clk(clk), .rst(rst), .acc(acc), .acc_data(req_data),
    .wb_en(live && !fin), .wb_idx(wb_idx), .wb_data(o_data),
    .iss_en(iss_en), .iss_idx(iss_idx), .cancel(cancel),
    .ent_valid(ent_valid), .iss_data(iss_data)
  );

  always_ff @(posedge clk) begin
    for (int s = 0; s < int'(N); s++) begin
      if (rst || cancel[s]) busy_q[s] <= 1'b0;
      else if (acc[s]) busy_q[s] <= 1'b1;
      else if (fin && (int'(o_slot) == s)) busy_q[s] <= 1'b0;
    end
  end

  assign res_valid = fin;
  assign res_slot  = o_slot;
  assign res_data  = o_data;

  for (genvar s = 0; s < int'(N); s++) begin : g_chk
    assert_cancel_frees_R7: assert property (@(posedge clk) disable iff (rst)
      cancel[s] |=> !busy_q[s]);
  end
  assert_res_owner_R2: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> busy_q[res_slot]);
  assert_res_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !(res_valid && res_slot == $past(res_slot)));
endmodule

// File: tb/recirc_sched_tb.sv
`timescale 1ns/1ps
module recirc_sched_tb;
  localparam int N = 10, P = 4, DW = 16, LAT = 3, SW = 4;
  localparam int MASK = (1 << DW) - 1;

  logic clk = 1'b0, rst = 1'b1;
  logic [N-1:0] req_valid = '0, cancel = '0;
  logic [N*DW-1:0] req_data = '0;
  logic [N-1:0] req_ready;
  logic res_valid;
  logic [SW-1:0] res_slot;
  logic [DW-1:0] res_data;

  always #10 clk = ~clk;

  recirc_sched #(.N(N), .P(P), .DW(DW), .LAT(LAT)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_data(req_data), .cancel(cancel), .res_valid(res_valid),
    .res_slot(res_slot), .res_data(res_data)
  );

  int checks = 0, fails = 0, done_flag = 0;
  // behavioural model: 0 idle, 1 waiting, 2 in pipeline
  int st[N], pas[N], dat[N], cnt[N];
  int accepted = 0, finished = 0, killed = 0, pulses = 0;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic cycle();
    int ost[N], opas[N];
    int ps, pp, es, ed;
    bit ev;
    bit [N-1:0] er;
    #1;
    ev = 0; es = 0; ed = 0;
    for (int s = 0; s < N; s++) begin
      er[s] = (st[s] == 0) && !cancel[s];
      if (st[s] == 2 && cnt[s] == LAT - 1 && pas[s] == P - 1 && !cancel[s]) begin
        ev = 1; es = s; ed = dat[s];
      end
    end
    check(req_ready == er, "R2 req_ready", int'(req_ready), int'(er));
    check(res_valid == ev, "R5 R7 res_valid", int'(res_valid), int'(ev));
    if (ev && res_valid) begin
      check(int'(res_slot) == es, "R5 res_slot", int'(res_slot), es);
      check(int'(res_data) == ed, "R4 res_data", int'(res_data), ed);
    end
    if (res_valid) pulses++;
    // R3 pick from state before this edge: parked by pass then slot, then fresh
    ps = -1; pp = 0;
    for (int p = 1; p < P && ps < 0; p++)
      for (int s = 0; s < N && ps < 0; s++)
        if (st[s] == 1 && pas[s] == p && !cancel[s]) begin ps = s; pp = p; end
    for (int s = 0; s < N && ps < 0; s++)
      if (st[s] == 1 && pas[s] == 0 && !cancel[s]) begin ps = s; pp = 0; end
    for (int s = 0; s < N; s++) begin
      ost[s] = st[s]; opas[s] = pas[s];
    end
    for (int s = 0; s < N; s++) begin
      if (cancel[s]) begin
        if (ost[s] != 0) killed++;
        st[s] = 0;
      end else if (ost[s] == 2) begin
        if (cnt[s] == LAT - 1) begin
          if (opas[s] == P - 1) begin st[s] = 0; finished++; end
          else begin st[s] = 1; pas[s] = opas[s] + 1; end
        end else cnt[s]++;
      end
    end
    if (ps >= 0) begin
      st[ps] = 2; cnt[ps] = 0; dat[ps] = (dat[ps] + pp + 1) & MASK;
    end
    for (int s = 0; s < N; s++)
      if (req_valid[s] && er[s]) begin
        st[s] = 1; pas[s] = 0; dat[s] = int'(req_data[s*DW +: DW]); accepted++;
      end
    @(negedge clk);
  endtask

  initial begin
    for (int s = 0; s < N; s++) begin st[s] = 0; pas[s] = 0; dat[s] = 0; cnt[s] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check(req_ready == {N{1'b1}}, "R1 ready after reset", int'(req_ready), (1 << N) - 1);
    check(res_valid == 1'b0, "R1 res_valid after reset", int'(res_valid), 0);
    // lone request with wrap: 0xFFF8 + 10 -> 2 (R4)
    req_valid[3] = 1'b1; req_data[3*DW +: DW] = 16'hFFF8;
    cycle();
    req_valid = '0;
    repeat (30) cycle();
    // every slot at once: exercises R3 ordering
    for (int s = 0; s < N; s++) begin
      req_valid[s] = 1'b1; req_data[s*DW +: DW] = DW'(s * 1000 + 7);
    end
    cycle();
    req_valid = '0;
    repeat (80) cycle();
    // random load, then random load with cancels (R7)
    for (int c = 0; c < 5000; c++) begin
      for (int s = 0; s < N; s++) begin
        if (!req_valid[s] || req_ready[s]) begin
          req_valid[s] = ($urandom % 4) == 0;
          req_data[s*DW +: DW] = DW'($urandom);
        end
        cancel[s] = (c >= 2000) && (($urandom % 64) == 0);
      end
      cycle();
    end
    req_valid = '0; cancel = '0;
    repeat (150) cycle();
    // R6: nothing lost; R8: one pulse per finished operation
    check(accepted == finished + killed, "R6 ops accounted", accepted, finished + killed);
    check(pulses == finished, "R8 pulse count", pulses, finished);
    check(killed > 0, "R7 cancels exercised", killed, 1);
    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (done_flag == 0) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule